// File: doc/BRIEF.md
# Scan Instruction Register and Data Path Selector

This block sits beside a test access port state machine. It holds the active test instruction and picks the serial data register that sits between the scan input and the scan output. The state machine supplies one-cycle strobes for capture, shift and update of the instruction and data scans. It also supplies a level that marks the reset state and a level that marks the idle state. A 4-bit instruction shifts in least significant bit first. It becomes active only when the update strobe arrives. The active instruction is decoded into a data-register select and three pin-mode controls.

The block contains the one-bit bypass stage, a 32-bit identification register, a 32-bit user code register and a self-test result register. The boundary register lives outside the block. It is reached through a serial input, a serial output and gated strobes. The self-test engine is outside too. It gets only a start pulse from this block, and it returns a result word that this block captures.

Top module: `scan_instr_sel`

## Requirements
- R1: After trst_n is released, and after any rising edge of tck while tlr is high, cur_op equals 4'b1000 (identification instruction) when HAS_ID is 1, or 4'b1111 when it is 0. If tlr and update_ir are both high on the same edge, the reset value wins.
- R2: capture_ir loads the fixed pattern 4'b0001. During shift_ir, tdo presents that pattern least significant bit first. cur_op changes only on an edge with update_ir or tlr high.
- R3: Opcodes 4'b0110 (clamp), 4'b0111 (high-impedance), 4'b1111 and every undefined code select the bypass stage. That stage captures 0 and delays tdi by exactly one tck before it appears on tdo.
- R4: Opcode 4'b1000 selects the identification register. It captures ID_VAL with bit 0 forced to 1, and shifts out least significant bit first.
- R5: Opcode 4'b1001 selects the user code register. It captures USER_VAL and shifts out least significant bit first.
- R6: Opcodes 4'b0000, 4'b0001, 4'b0011 and 4'b0100 select the external boundary register. During shift_dr, tdo follows bsr_so and bsr_si follows tdi. bsr_capture, bsr_shift and bsr_update pulse only while that register is selected.
- R7: pin_drive is high for opcodes 4'b0000, 4'b0100 and 4'b0110. pin_hiz is high only for 4'b0111. core_test is high for 4'b0100 and 4'b0101.
- R8: Opcode 4'b1111 and the undefined codes (for example 4'b1010 and 4'b1100) leave all three mode controls low.
- R9: Opcode 4'b0101 selects the self-test result register, which captures bist_result. bist_start pulses for one cycle when run_idle rises under this opcode, and stays low when run_idle rises under any other instruction.
- R10: Outside shift_ir and shift_dr, tdo is 0 and tdo_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tlr | input | 1 | Controller is in its reset state |
| run_idle | input | 1 | Controller is in its idle state |
| capture_ir | input | 1 | Instruction capture strobe |
| shift_ir | input | 1 | Instruction shift strobe |
| update_ir | input | 1 | Instruction update strobe |
| capture_dr | input | 1 | Data capture strobe |
| shift_dr | input | 1 | Data shift strobe |
| update_dr | input | 1 | Data update strobe |
| tdi | input | 1 | Serial scan input |
| bsr_so | input | 1 | Serial output of the external boundary register |
| bist_result | input | BIST_W | Result word from the self-test engine |
| tdo | output | 1 | Serial scan output |
| tdo_en | output | 1 | Scan output valid |
| bsr_si | output | 1 | Serial input to the boundary register |
| bsr_capture | output | 1 | Boundary capture strobe |
| bsr_shift | output | 1 | Boundary shift strobe |
| bsr_update | output | 1 | Boundary update strobe |
| pin_drive | output | 1 | Pins driven from boundary cells |
| pin_hiz | output | 1 | All outputs floated |
| core_test | output | 1 | Core logic under test |
| bist_start | output | 1 | Self-test start pulse |
| cur_op | output | 4 | Active instruction |

## Verification
Two events can land on the same tck edge: the reset-state level and the instruction update strobe. In that case the reset instruction must win over the freshly shifted opcode. The bench provokes this by shifting the clamp opcode and then raising tlr and update_ir together. It judges the result from cur_op and the mode pins, which must show the reset instruction. A second case is bist_start, which is combinational from run_idle. The bench checks it in the same cycle that run_idle rises and again one cycle later.

// File: rtl/scan_instr_pkg.sv
package scan_instr_pkg;
  localparam int IR_W = 4;
  typedef logic [IR_W-1:0] op_t;

  localparam op_t OP_EXTEST = 4'b0000;
  localparam op_t OP_SAMPLE = 4'b0001;
  localparam op_t OP_PRELOAD = 4'b0011;
  localparam op_t OP_INTEST = 4'b0100;
  localparam op_t OP_RUNBIST = 4'b0101;
  localparam op_t OP_CLAMP = 4'b0110;
  localparam op_t OP_HIGHZ = 4'b0111;
  localparam op_t OP_IDCODE = 4'b1000;
  localparam op_t OP_USERCODE = 4'b1001;
  localparam op_t OP_BYPASS = 4'b1111;
  localparam op_t IR_CAPTURE = 4'b0001;

  typedef enum logic [2:0] {SEL_BYP, SEL_BSR, SEL_ID, SEL_USER, SEL_BIST} dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    pin_drive;
    logic    pin_hiz;
    logic    core_test;
    logic    bist;
  } dec_t;

  function automatic op_t reset_op(bit has_id);
    return has_id ? OP_IDCODE : OP_BYPASS;
  endfunction

  function automatic dec_t decode_op(op_t op, bit has_id);
    dec_t d;
    d.sel = SEL_BYP;
    d.pin_drive = 1'b0;
    d.pin_hiz = 1'b0;
    d.core_test = 1'b0;
    d.bist = 1'b0;
    case (op)
      OP_EXTEST:   begin d.sel = SEL_BSR; d.pin_drive = 1'b1; end
      OP_SAMPLE:   d.sel = SEL_BSR;
      OP_PRELOAD:  d.sel = SEL_BSR;
      OP_INTEST:   begin d.sel = SEL_BSR; d.pin_drive = 1'b1; d.core_test = 1'b1; end
      OP_RUNBIST:  begin d.sel = SEL_BIST; d.core_test = 1'b1; d.bist = 1'b1; end
      OP_CLAMP:    d.pin_drive = 1'b1;
      OP_HIGHZ:    d.pin_hiz = 1'b1;
      OP_IDCODE:   d.sel = has_id ? SEL_ID : SEL_BYP;
      OP_USERCODE: d.sel = SEL_USER;
      default:     d.sel = SEL_BYP;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/scan_ir_stage.sv
module scan_ir_stage
  import scan_instr_pkg::*;
#(
  parameter op_t RST_OP = OP_IDCODE
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tlr,
  input  logic capture_ir,
  input  logic shift_ir,
  input  logic update_ir,
  input  logic tdi,
  output logic ir_so,
  output op_t  cur_op
);
  op_t sr_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q <= IR_CAPTURE;
    end else if (capture_ir) begin
      sr_q <= IR_CAPTURE;
    end else if (shift_ir) begin
      sr_q <= {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      cur_op <= RST_OP;
    end else if (tlr) begin
      cur_op <= RST_OP;
    end else if (update_ir) begin
      cur_op <= sr_q;
    end
  end

  assign ir_so = sr_q[0];
endmodule

// File: rtl/scan_shift_reg.sv
module scan_shift_reg #(
  parameter int W = 32
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         cap,
  input  logic         shf,
  input  logic         si,
  input  logic [W-1:0] cap_val,
  output logic         so
);
  logic [W-1:0] q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      q <= '0;
    end else if (cap) begin
      q <= cap_val;
    end else if (shf) begin
      q <= {si, q[W-1:1]};
    end
  end

  assign so = q[0];
endmodule

// File: rtl/scan_dr_bank.sv
module scan_dr_bank
  import scan_instr_pkg::*;
#(
  parameter bit          HAS_ID   = 1'b1,
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VAL   = 32'h1A5C_3E00,
  parameter logic [ID_W-1:0] USER_VAL = 32'hC0DE_5AA6,
  parameter int          BIST_W   = 8
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              tdi,
  input  dr_sel_e           sel,
  input  logic [BIST_W-1:0] bist_result,
  output logic              byp_bit,
  output logic              id_so,
  output logic              user_so,
  output logic              bist_so
);
  localparam logic [ID_W-1:0] ID_CAP = {ID_VAL[ID_W-1:1], 1'b1};

  logic byp_sel;
  assign byp_sel = (sel == SEL_BYP);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_bit <= 1'b0;
    end else if (capture_dr && byp_sel) begin
      byp_bit <= 1'b0;
    end else if (shift_dr && byp_sel) begin
      byp_bit <= tdi;
    end
  end

  generate
    if (HAS_ID) begin : g_id
      scan_shift_reg #(.W(ID_W)) u_id (
        .tck(tck), .trst_n(trst_n),
        .cap(capture_dr && sel == SEL_ID), .shf(shift_dr && sel == SEL_ID),
        .si(tdi), .cap_val(ID_CAP), .so(id_so)
      );
    end else begin : g_no_id
      assign id_so = 1'b0;
    end
  endgenerate

  scan_shift_reg #(.W(ID_W)) u_user (
    .tck(tck), .trst_n(trst_n),
    .cap(capture_dr && sel == SEL_USER), .shf(shift_dr && sel == SEL_USER),
    .si(tdi), .cap_val(USER_VAL), .so(user_so)
  );

  scan_shift_reg #(.W(BIST_W)) u_bist (
    .tck(tck), .trst_n(trst_n),
    .cap(capture_dr && sel == SEL_BIST), .shf(shift_dr && sel == SEL_BIST),
    .si(tdi), .cap_val(bist_result), .so(bist_so)
  );
endmodule

// File: rtl/scan_instr_sel.sv
module scan_instr_sel
  import scan_instr_pkg::*;
#(
  parameter bit          HAS_ID   = 1'b1,
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VAL   = 32'h1A5C_3E00,
  parameter logic [ID_W-1:0] USER_VAL = 32'hC0DE_5AA6,
  parameter int          BIST_W   = 8
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tlr,
  input  logic              run_idle,
  input  logic              capture_ir,
  input  logic              shift_ir,
  input  logic              update_ir,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic              bsr_so,
  input  logic [BIST_W-1:0] bist_result,
  output logic              tdo,
  output logic              tdo_en,
  output logic              bsr_si,
  output logic              bsr_capture,
  output logic              bsr_shift,
  output logic              bsr_update,
  output logic              pin_drive,
  output logic              pin_hiz,
  output logic              core_test,
  output logic              bist_start,
  output logic [IR_W-1:0]   cur_op
);
  localparam op_t RST_OP = reset_op(HAS_ID);

  logic ir_so, byp_bit, id_so, user_so, bist_so;
  logic run_idle_d;
  logic byp_sel, bsr_sel;
  dec_t dec;

  scan_ir_stage #(.RST_OP(RST_OP)) u_ir (
    .tck(tck), .trst_n(trst_n), .tlr(tlr),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
    .tdi(tdi), .ir_so(ir_so), .cur_op(cur_op)
  );

  assign dec = decode_op(cur_op, HAS_ID);
  assign byp_sel = (dec.sel == SEL_BYP);
  assign bsr_sel = (dec.sel == SEL_BSR);

  scan_dr_bank #(
    .HAS_ID(HAS_ID), .ID_W(ID_W), .ID_VAL(ID_VAL),
    .USER_VAL(USER_VAL), .BIST_W(BIST_W)
  ) u_bank (
    .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .tdi(tdi), .sel(dec.sel), .bist_result(bist_result),
    .byp_bit(byp_bit), .id_so(id_so), .user_so(user_so), .bist_so(bist_so)
  );

  always_comb begin
    tdo = 1'b0;
    if (shift_ir) begin
      tdo = ir_so;
    end else if (shift_dr) begin
      case (dec.sel)
        SEL_BSR:  tdo = bsr_so;
        SEL_ID:   tdo = id_so;
        SEL_USER: tdo = user_so;
        SEL_BIST: tdo = bist_so;
        default:  tdo = byp_bit;
      endcase
    end
  end
  assign tdo_en = shift_ir | shift_dr;

  assign bsr_si = tdi;
  assign bsr_capture = capture_dr & bsr_sel;
  assign bsr_shift = shift_dr & bsr_sel;
  assign bsr_update = update_dr & bsr_sel;

  assign pin_drive = dec.pin_drive;
  assign pin_hiz = dec.pin_hiz;
  assign core_test = dec.core_test;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) run_idle_d <= 1'b0;
    else         run_idle_d <= run_idle;
  end
  assign bist_start = run_idle & ~run_idle_d & dec.bist;
endmodule

// File: rtl/scan_instr_sel_chk.sv
module scan_instr_sel_chk
  import scan_instr_pkg::*;
#(
  parameter op_t RST_OP = OP_IDCODE
) (
  input logic    tck,
  input logic    trst_n,
  input logic    tlr,
  input logic    update_ir,
  input logic    shift_ir,
  input logic    shift_dr,
  input logic    tdi,
  input logic    tdo,
  input op_t     cur_op,
  input logic    bist_start,
  input logic    bsr_shift,
  input logic    byp_sel,
  input logic    byp_bit
);
  // R1
  tlr_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |=> cur_op == RST_OP);

  // R2
  op_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!tlr && !update_ir) |=> $stable(cur_op));

  // R3
  bypass_delay_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && byp_sel) |=> byp_bit == $past(tdi));

  // R6
  bsr_shift_gate_chk: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_shift |-> shift_dr);

  // R9
  bist_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
    bist_start |=> !bist_start);

  // R10
  tdo_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!shift_ir && !shift_dr) |-> !tdo);
endmodule

bind scan_instr_sel scan_instr_sel_chk #(.RST_OP(RST_OP)) u_chk (
  .tck(tck), .trst_n(trst_n), .tlr(tlr), .update_ir(update_ir),
  .shift_ir(shift_ir), .shift_dr(shift_dr), .tdi(tdi), .tdo(tdo),
  .cur_op(cur_op), .bist_start(bist_start), .bsr_shift(bsr_shift),
  .byp_sel(byp_sel), .byp_bit(byp_bit)
);

// File: tb/scan_instr_sel_bench.sv
module scan_instr_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_V = 32'h1A5C_3E00;
  localparam logic [31:0] USER_V = 32'hC0DE_5AA6;
  localparam logic [7:0] BIST_V = 8'h9B;

  // vector: {opcode[3:0], sel[2:0] (0 byp,1 bsr,2 id,3 user,4 bist), drive, hiz, core}
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    {4'b0000, 3'd1, 3'b100}, {4'b0001, 3'd1, 3'b000}, {4'b0011, 3'd1, 3'b000},
    {4'b0100, 3'd1, 3'b101}, {4'b0101, 3'd4, 3'b001}, {4'b0110, 3'd0, 3'b100},
    {4'b0111, 3'd0, 3'b010}, {4'b1000, 3'd2, 3'b000}, {4'b1001, 3'd3, 3'b000},
    {4'b1010, 3'd0, 3'b000}, {4'b1100, 3'd0, 3'b000}, {4'b1111, 3'd0, 3'b000}
  };

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tlr = 0, run_idle = 0, capture_ir = 0, shift_ir = 0, update_ir = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0, bsr_so = 0;
  logic [7:0] bist_result = BIST_V;
  logic tdo, tdo_en, bsr_si, bsr_capture, bsr_shift, bsr_update;
  logic pin_drive, pin_hiz, core_test, bist_start;
  logic [3:0] cur_op;

  int checks = 0;
  int errors = 0;
  int bsr_pulses = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  scan_instr_sel #(.ID_VAL(ID_V), .USER_VAL(USER_V)) u_scan_instr_sel (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .run_idle(run_idle),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .bsr_so(bsr_so), .bist_result(bist_result),
    .tdo(tdo), .tdo_en(tdo_en), .bsr_si(bsr_si), .bsr_capture(bsr_capture),
    .bsr_shift(bsr_shift), .bsr_update(bsr_update), .pin_drive(pin_drive),
    .pin_hiz(pin_hiz), .core_test(core_test), .bist_start(bist_start),
    .cur_op(cur_op)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
    logic [3:0] prev;
    prev = cur_op;
    @(negedge tck) capture_ir = 1;
    @(negedge tck) capture_ir = 0; shift_ir = 1;
    for (int i = 0; i < 4; i++) begin
      #1 cap[i] = tdo;
      tdi = op[i];
      @(negedge tck);
    end
    shift_ir = 0;
    #1 chk("R2 opcode held before update", cur_op, prev);
    update_ir = 1;
    @(negedge tck) update_ir = 0;
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    bsr_pulses = 0;
    @(negedge tck) capture_dr = 1;
    #1 if (bsr_capture) bsr_pulses++;
    @(negedge tck) capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      bsr_so = ~din[i];
      #1 dout[i] = tdo;
      if (bsr_shift && bsr_si == tdi) bsr_pulses++;
      @(negedge tck);
    end
    shift_dr = 0; update_dr = 1;
    #1 if (bsr_update) bsr_pulses++;
    @(negedge tck) update_dr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] cap;
    logic [63:0] dout, exp;
    int n;
    string tag;

    #(CLK_PERIOD * 2 + 2);
    chk("R1 reset opcode", cur_op, 4'b1000);
    chk("R10 tdo idle", {tdo, tdo_en}, 2'b00);
    chk("R7 reset modes", {pin_drive, pin_hiz, core_test}, 3'b000);
    trst_n = 1;

    for (int v = 0; v < NV; v++) begin
      logic [3:0] op;
      logic [2:0] sel;
      op = VEC[v][9:6];
      sel = VEC[v][5:3];
      load_ir(op, cap);
      chk("R2 captured pattern", cap, 4'b0001);
      chk("R2 opcode after update", cur_op, op);
      tag = (sel == 0 && op != 4'b0110 && op != 4'b0111) ? "R8 modes" : "R7 modes";
      chk(tag, {pin_drive, pin_hiz, core_test}, VEC[v][2:0]);
      case (sel)
        3'd0: begin n = 2; tag = "R3 bypass scan"; exp = 64'b10; end
        3'd1: begin n = 4; tag = "R6 boundary scan"; exp = 64'b1001; end
        3'd2: begin n = 32; tag = "R4 id scan"; exp = {32'h0, ID_V | 32'h1}; end
        3'd3: begin n = 32; tag = "R5 user scan"; exp = {32'h0, USER_V}; end
        default: begin n = 8; tag = "R9 result scan"; exp = {56'h0, BIST_V}; end
      endcase
      scan_dr(n, (sel == 1) ? 64'b0110 : 64'hFFFF_FFFF_FFFF_FFFF, dout);
      chk(tag, dout, exp);
      chk("R6 boundary strobes", bsr_pulses, (sel == 1) ? n + 2 : 0);
      chk("R10 tdo after scan", {tdo, tdo_en}, 2'b00);
    end

    // R9: start pulse under self-test opcode, one cycle wide
    load_ir(4'b0101, cap);
    @(negedge tck) run_idle = 1;
    #1 chk("R9 start pulse", bist_start, 1'b1);
    @(negedge tck);
    #1 chk("R9 pulse ends", bist_start, 1'b0);
    @(negedge tck) run_idle = 0;

    // R9: no start under identification opcode; id register kept
    load_ir(4'b1000, cap);
    @(negedge tck) run_idle = 1;
    #1 chk("R9 no start other opcode", bist_start, 1'b0);
    @(negedge tck) run_idle = 0;

    // R1: tlr and update_ir on the same edge, reset wins
    load_ir(4'b1111, cap);
    @(negedge tck) capture_ir = 1;
    @(negedge tck) capture_ir = 0; shift_ir = 1;
    for (int i = 0; i < 4; i++) begin
      tdi = 4'b0110 >> i;
      @(negedge tck);
    end
    shift_ir = 0; update_ir = 1; tlr = 1;
    @(negedge tck) update_ir = 0; tlr = 0;
    #1 chk("R1 reset beats update", cur_op, 4'b1000);
    chk("R1 no clamp modes", {pin_drive, pin_hiz, core_test}, 3'b000);

    // R1: tlr alone from another opcode
    load_ir(4'b0111, cap);
    @(negedge tck) tlr = 1;
    @(negedge tck) tlr = 0;
    #1 chk("R1 tlr restores", cur_op, 4'b1000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule